// File: doc/BRIEF.md
# Flash Address Range Sequencer

This block walks a 12-bit flash address across a range on behalf of a self-programming command. Software loads a start pointer and an end compare value through a small byte-wide register port, then pulses a start input with a two-bit operation code. The sequencer first checks that the range is legal for that operation. It then puts out one registered address with a valid strobe per cycle, starting at the pointer and ending at the compare value.

The pointer counts up as it goes and is left equal to the compare value, so software reloads it before every command. A rejected command sets an error flag and leaves all state alone. An accepted command raises busy, streams the addresses, pulses done for one cycle, and then drops busy. While busy is high, register writes and further starts are ignored.

Top module: `flash_addr_walker`

## Requirements
- R1: Register index 0 is pointer low (address bits 7..0), 1 is pointer high (bits 11..8 in its bits 3..0), 2 is compare high and 3 is compare low. All eight written bits read back on reg_rdata one cycle after reg_addr is presented.
- R2: While rst is high at a clock edge, both compare registers clear to 00h and busy, done, err and flash_addr_vld go low.
- R3: An accepted start raises busy in the cycle after the start edge. flash_addr_vld is then high for one cycle per address, from the pointer to the compare value inclusive, on consecutive cycles, with flash_addr rising by one each time.
- R4: done is high for exactly one cycle, in the cycle after the last address strobe. busy is still high in that cycle and low in the next.
- R5: After a completed command, the pointer registers read back equal to the compare registers.
- R6: If bits 7..4 of pointer high or of compare high are not zero at start, the start is rejected.
- R7: If bits 3..0 of compare high differ from bits 3..0 of pointer high, the start is rejected.
- R8: If compare low is less than pointer low, the start is rejected.
- R9: The operation code is 0 for erase, 1 for write, 2 for verify and 3 for blank check. Erase is rejected unless compare low is 00h, and blank check is rejected unless compare low is FFh. Write and verify accept any end at or above the start.
- R10: A start while idle updates err in the cycle after the start edge. err is set on a rejected start, which raises no busy and no strobe and changes no register. err is cleared on an accepted start.
- R11: While busy is high, register writes and cmd_start have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 2 | Register index for write and readback |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered readback of the indexed register |
| cmd_start | input | 1 | Start pulse for a command |
| cmd_op | input | 2 | Operation code: 0 erase, 1 write, 2 verify, 3 blank check |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last start was rejected |
| flash_addr | output | 12 | Address to the flash array |
| flash_addr_vld | output | 1 | Strobe qualifying flash_addr |

## Verification
Take the clock edge that samples cmd_start as edge 0. Busy and err are due after edge 0. The first address strobe is due after edge 1, and for an N-address range the last strobe is due after edge N. Done is due after edge N+1, and busy falls after edge N+2. Readback data is due one edge after reg_addr changes. All inputs are driven at falling edges and all outputs are sampled at the next falling edge, so every check lands in the cycle its result is due. The strobe loop compares each address against a counter seeded from the loaded pointer.

// File: rtl/fa_pkg.sv
package fa_pkg;
  typedef enum logic [1:0] {
    OP_ERASE  = 2'd0,
    OP_WRITE  = 2'd1,
    OP_VERIFY = 2'd2,
    OP_BLANK  = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } st_e;

  localparam logic [1:0] IX_PTR_LO = 2'd0;
  localparam logic [1:0] IX_PTR_HI = 2'd1;
  localparam logic [1:0] IX_CMP_HI = 2'd2;
  localparam logic [1:0] IX_CMP_LO = 2'd3;
endpackage

// File: rtl/fa_regfile.sv
module fa_regfile #(
  parameter int HI_W = 4,
  parameter int DW   = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [1:0]    idx,
  input  logic [DW-1:0] wr_data,
  input  logic          lock,
  input  logic          step,
  output logic [DW-1:0] rd_data,
  output logic [DW-1:0] ptr_hi_raw,
  output logic [DW-1:0] ptr_lo,
  output logic [DW-1:0] cmp_hi_raw,
  output logic [DW-1:0] cmp_lo
);
  import fa_pkg::*;
  localparam int AW = HI_W + DW;
  localparam logic [AW-1:0] ONE = AW'(1);

  logic [DW-1:0] p_hi_q, p_lo_q, c_hi_q, c_lo_q;
  logic [AW-1:0] nxt;

  assign nxt = {p_hi_q[HI_W-1:0], p_lo_q} + ONE;

  // pointer has no reset value
  always_ff @(posedge clk) begin
    if (step) begin
      p_lo_q <= nxt[DW-1:0];
      p_hi_q <= {p_hi_q[DW-1:HI_W], nxt[AW-1:DW]};
    end else if (wr_en && !lock) begin
      if (idx == IX_PTR_LO) p_lo_q <= wr_data;
      if (idx == IX_PTR_HI) p_hi_q <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      c_hi_q <= '0;
      c_lo_q <= '0;
    end else if (wr_en && !lock) begin
      if (idx == IX_CMP_HI) c_hi_q <= wr_data;
      if (idx == IX_CMP_LO) c_lo_q <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else begin
      case (idx)
        IX_PTR_LO: rd_data <= p_lo_q;
        IX_PTR_HI: rd_data <= p_hi_q;
        IX_CMP_HI: rd_data <= c_hi_q;
        default:   rd_data <= c_lo_q;
      endcase
    end
  end

  assign ptr_hi_raw = p_hi_q;
  assign ptr_lo     = p_lo_q;
  assign cmp_hi_raw = c_hi_q;
  assign cmp_lo     = c_lo_q;
endmodule

// File: rtl/fa_range_check.sv
module fa_range_check #(
  parameter int HI_W = 4,
  parameter int DW   = 8
) (
  input  logic [1:0]    op,
  input  logic [DW-1:0] ptr_hi_raw,
  input  logic [DW-1:0] ptr_lo,
  input  logic [DW-1:0] cmp_hi_raw,
  input  logic [DW-1:0] cmp_lo,
  output logic          legal
);
  import fa_pkg::*;
  logic rsv_bad, blk_bad, ord_bad, end_bad;

  assign rsv_bad = (|ptr_hi_raw[DW-1:HI_W]) | (|cmp_hi_raw[DW-1:HI_W]);
  assign blk_bad = ptr_hi_raw[HI_W-1:0] != cmp_hi_raw[HI_W-1:0];
  assign ord_bad = cmp_lo < ptr_lo;

  always_comb begin
    case (op_e'(op))
      OP_ERASE: end_bad = cmp_lo != '0;
      OP_BLANK: end_bad = cmp_lo != '1;
      default:  end_bad = 1'b0;
    endcase
  end

  assign legal = !(rsv_bad || blk_bad || ord_bad || end_bad);
endmodule

// File: rtl/fa_step_fsm.sv
module fa_step_fsm #(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          legal,
  input  logic [AW-1:0] cur,
  input  logic          at_end,
  output logic          step,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic          strobe,
  output logic [AW-1:0] addr
);
  import fa_pkg::*;
  st_e st;

  assign step = (st == ST_RUN) && !at_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      busy   <= 1'b0;
      done   <= 1'b0;
      err    <= 1'b0;
      strobe <= 1'b0;
      addr   <= '0;
    end else begin
      case (st)
        ST_RUN: begin
          strobe <= 1'b1;
          addr   <= cur;
          if (at_end) st <= ST_FIN;
        end
        ST_FIN: begin
          strobe <= 1'b0;
          done   <= 1'b1;
          st     <= ST_IDLE;
        end
        default: begin
          done   <= 1'b0;
          strobe <= 1'b0;
          busy   <= 1'b0;
          if (start && !busy) begin
            if (legal) begin
              busy <= 1'b1;
              err  <= 1'b0;
              st   <= ST_RUN;
            end else begin
              err  <= 1'b1;
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/flash_addr_walker.sv
module flash_addr_walker #(
  parameter int HI_W = 4,
  parameter int DW   = 8,
  localparam int AW  = HI_W + DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_we,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          cmd_start,
  input  logic [1:0]    cmd_op,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic [AW-1:0] flash_addr,
  output logic          flash_addr_vld
);
  logic [DW-1:0] p_hi, p_lo, c_hi, c_lo;
  logic [AW-1:0] ptr_full, cmp_full;
  logic          legal, step;

  fa_regfile #(.HI_W(HI_W), .DW(DW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(reg_we), .idx(reg_addr), .wr_data(reg_wdata),
    .lock(busy), .step(step), .rd_data(reg_rdata),
    .ptr_hi_raw(p_hi), .ptr_lo(p_lo), .cmp_hi_raw(c_hi), .cmp_lo(c_lo)
  );

  fa_range_check #(.HI_W(HI_W), .DW(DW)) u_chk_range (
    .op(cmd_op), .ptr_hi_raw(p_hi), .ptr_lo(p_lo),
    .cmp_hi_raw(c_hi), .cmp_lo(c_lo), .legal(legal)
  );

  assign ptr_full = {p_hi[HI_W-1:0], p_lo};
  assign cmp_full = {c_hi[HI_W-1:0], c_lo};

  fa_step_fsm #(.AW(AW)) u_fsm (
    .clk(clk), .rst(rst), .start(cmd_start), .legal(legal),
    .cur(ptr_full), .at_end(ptr_full == cmp_full), .step(step),
    .busy(busy), .done(done), .err(err),
    .strobe(flash_addr_vld), .addr(flash_addr)
  );
endmodule

// File: rtl/fa_walker_chk.sv
module fa_walker_chk #(
  parameter int AW = 12
) (
  input logic          clk,
  input logic          rst,
  input logic          busy,
  input logic          done,
  input logic          err,
  input logic          strobe,
  input logic [AW-1:0] addr,
  input logic [AW-1:0] cmp_full
);
  localparam logic [AW-1:0] ONE = AW'(1);

  p_reset_clear_r2: assert property (@(posedge clk)
    rst |=> (cmp_full == '0 && !busy && !done && !err && !strobe));

  p_strobe_in_busy_r3: assert property (@(posedge clk) disable iff (rst)
    strobe |-> busy);

  p_addr_consecutive_r3: assert property (@(posedge clk) disable iff (rst)
    (strobe && $past(strobe)) |-> addr == $past(addr) + ONE);

  p_done_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_busy_drop_r4: assert property (@(posedge clk) disable iff (rst)
    done |=> !busy);

  p_done_after_strobe_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> ($past(strobe) && !strobe && busy));

  p_reject_idle_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(err) |-> !busy);

  p_cmp_frozen_r11: assert property (@(posedge clk) disable iff (rst)
    $past(busy) |-> $stable(cmp_full));
endmodule

bind flash_addr_walker fa_walker_chk #(.AW(AW)) u_walker_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done), .err(err),
  .strobe(flash_addr_vld), .addr(flash_addr), .cmp_full(cmp_full)
);

// File: tb/flash_addr_walker_test.sv
module flash_addr_walker_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [7:0]  reg_wdata = 8'h00;
  logic [7:0]  reg_rdata;
  logic        cmd_start = 1'b0;
  logic [1:0]  cmd_op = 2'd0;
  logic        busy, done, err, flash_addr_vld;
  logic [11:0] flash_addr;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  flash_addr_walker uut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmd_start(cmd_start),
    .cmd_op(cmd_op), .busy(busy), .done(done), .err(err),
    .flash_addr(flash_addr), .flash_addr_vld(flash_addr_vld)
  );

  typedef struct packed {
    logic [1:0] op;
    logic [7:0] phi;
    logic [7:0] plo;
    logic [7:0] chi;
    logic [7:0] clo;
    logic       bad;
    logic [8:0] n;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{2'd1, 8'h03, 8'h10, 8'h03, 8'h14, 1'b0, 9'd5},   // R3 write range
    '{2'd2, 8'h05, 8'h20, 8'h05, 8'h20, 1'b0, 9'd1},   // R9 verify single
    '{2'd0, 8'h02, 8'h00, 8'h02, 8'h00, 1'b0, 9'd1},   // R9 erase end 00h
    '{2'd3, 8'h07, 8'hF0, 8'h07, 8'hFF, 1'b0, 9'd16},  // R9 blank end FFh
    '{2'd0, 8'h02, 8'h00, 8'h02, 8'h05, 1'b1, 9'd0},   // R9 erase bad end
    '{2'd3, 8'h01, 8'h00, 8'h01, 8'hFE, 1'b1, 9'd0},   // R9 blank bad end
    '{2'd1, 8'h04, 8'h30, 8'h05, 8'h30, 1'b1, 9'd0},   // R7 block mismatch
    '{2'd2, 8'h01, 8'h40, 8'h01, 8'h3F, 1'b1, 9'd0},   // R8 end below start
    '{2'd1, 8'h13, 8'h00, 8'h03, 8'h02, 1'b1, 9'd0},   // R6 pointer reserved bit
    '{2'd1, 8'h03, 8'h00, 8'h83, 8'h02, 1'b1, 9'd0},   // R6 compare reserved bit
    '{2'd1, 8'h0F, 8'hFE, 8'h0F, 8'hFF, 1'b0, 9'd2},   // R3 top of space
    '{2'd2, 8'h00, 8'h00, 8'h00, 8'hFF, 1'b0, 9'd256}  // R3 full block
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic load(input logic [7:0] phi, plo, chi, clo);
    wr(2'd0, plo); wr(2'd1, phi); wr(2'd2, chi); wr(2'd3, clo);
  endtask

  task automatic start(input logic [1:0] op);
    @(negedge clk);
    cmd_start = 1'b1; cmd_op = op;
    @(negedge clk);
    cmd_start = 1'b0;
  endtask

  // Walk strobes until done; returns count of strobes
  task automatic collect(input logic [11:0] first, output int cnt);
    logic [11:0] expa;
    cnt = 0;
    expa = first;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (flash_addr_vld) begin
        if (flash_addr != expa)
          chk(1'b0, "R3 address sequence", int'(flash_addr), int'(expa));
        expa = expa + 12'd1;
        cnt++;
      end
      if (done) break;
    end
    chk(done === 1'b1 && flash_addr_vld === 1'b0, "R4 done after last strobe", int'(done), 1);
    chk(busy === 1'b1, "R4 busy during done", int'(busy), 1);
    @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0, "R4 busy and done low", int'({busy, done}), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R3 watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int cnt;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R2 reset state
    chk(busy === 1'b0 && done === 1'b0 && err === 1'b0 && flash_addr_vld === 1'b0,
        "R2 outputs after reset", int'({busy, done, err, flash_addr_vld}), 0);
    rd(2'd2, d); chk(d === 8'h00, "R2 compare high cleared", int'(d), 0);
    rd(2'd3, d); chk(d === 8'h00, "R2 compare low cleared", int'(d), 0);

    // R1 register map and readback
    load(8'hA5, 8'h3C, 8'h5A, 8'hC3);
    rd(2'd0, d); chk(d === 8'h3C, "R1 pointer low", int'(d), 'h3C);
    rd(2'd1, d); chk(d === 8'hA5, "R1 pointer high", int'(d), 'hA5);
    rd(2'd2, d); chk(d === 8'h5A, "R1 compare high", int'(d), 'h5A);
    rd(2'd3, d); chk(d === 8'hC3, "R1 compare low", int'(d), 'hC3);

    for (int v = 0; v < NV; v++) begin
      load(VECS[v].phi, VECS[v].plo, VECS[v].chi, VECS[v].clo);
      start(VECS[v].op);
      chk(err === VECS[v].bad, "R10 err after start", int'(err), int'(VECS[v].bad));
      chk(busy === !VECS[v].bad, "R10 busy after start", int'(busy), int'(!VECS[v].bad));
      if (VECS[v].bad) begin
        cnt = 0;
        for (int k = 0; k < 4; k++) begin
          @(negedge clk);
          if (flash_addr_vld || busy) cnt++;
        end
        chk(cnt == 0, "R10 rejected start stays idle", cnt, 0);
        rd(2'd0, d); chk(d === VECS[v].plo, "R10 pointer untouched", int'(d), int'(VECS[v].plo));
      end else begin
        collect({VECS[v].phi[3:0], VECS[v].plo}, cnt);
        chk(cnt == int'(VECS[v].n), "R3 strobe count", cnt, int'(VECS[v].n));
        rd(2'd0, d); chk(d === VECS[v].clo, "R5 pointer low consumed", int'(d), int'(VECS[v].clo));
        rd(2'd1, d); chk(d === VECS[v].chi, "R5 pointer high consumed", int'(d), int'(VECS[v].chi));
      end
    end

    // R11 writes and starts ignored while busy
    load(8'h06, 8'h00, 8'h06, 8'hFF);
    start(2'd2);
    wr(2'd3, 8'h10);
    wr(2'd0, 8'h55);
    start(2'd1);
    wr(2'd2, 8'h01);
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      if (done) break;
    end
    @(negedge clk);
    chk(err === 1'b0, "R11 start during busy ignored", int'(err), 0);
    rd(2'd3, d); chk(d === 8'hFF, "R11 compare low kept", int'(d), 'hFF);
    rd(2'd2, d); chk(d === 8'h06, "R11 compare high kept", int'(d), 'h06);
    rd(2'd0, d); chk(d === 8'hFF, "R11 pointer walked to end", int'(d), 'hFF);

    // R10 err cleared by a later accepted start
    load(8'h02, 8'h00, 8'h03, 8'h00);
    start(2'd1);
    chk(err === 1'b1, "R7 mismatch rejected", int'(err), 1);
    load(8'h03, 8'h08, 8'h03, 8'h09);
    start(2'd1);
    chk(err === 1'b0, "R10 err cleared", int'(err), 0);
    collect(12'h308, cnt);
    chk(cnt == 2, "R3 short range count", cnt, 2);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule